// File: doc/BRIEF.md
# Programmable Sync Pattern Transmitter

This block drives a serial transmit line with a programmable 16-bit synchronization word. It is used when no payload is being sent: it fills the line with idle or frame-delimiting syncs. One line bit is produced for each pulse of the serial bit enable. The word comes from a read/write pattern register. After reset that register holds two back-to-back HDLC flags (0x7E7E), so HDLC operation needs no write at all. Writing 0xD555 gives an Ethernet-style start delimiter, and any other value serves as the idle fill for transparent links.

While the sync request is held, the word is repeated with no gap bits between repetitions, always lowest-numbered bit first. At the start of each repetition the serializer takes a private copy of the register. A register write made partway through a word therefore changes only the next repetition. When the request drops, the word in progress runs to its end and the line then returns to its idle level. A one-clock strobe marks the last bit of every repetition.

Top module: `sync_pattern_tx`

## Requirements
- R1: The pattern register is 16 bits wide; a value written with the write enable appears on the read port in the clock cycle after the write edge.
- R2: After reset the read port shows 0x7E7E, the line output is at idle level 1, the active flag is 0 and the boundary strobe is 0.
- R3: Within a repetition the n-th transmitted bit (n = 0..15) equals bit n of the pattern, where bit 0 is the least significant bit.
- R4: While the sync request stays high, the bit enable that follows the last bit of one repetition starts the next repetition with its bit 0, so there are no gap bits.
- R5: The boundary strobe is high for exactly one clock, in the cycle in which bit 15 of a repetition first appears on the line, and is low at all other times.
- R6: A register write made while a repetition is in progress leaves the remaining bits of that repetition unchanged; the new value is used from the next repetition onward.
- R7: When the sync request is low at the bit enable that follows bit 15, the line returns to 1 and the active flag falls; it never falls before bit 15 has been sent.
- R8: While no repetition is in progress, the line stays at 1 whatever the bit enable and the register writes do.
- R9: The line output and the active flag change only in the clock cycle after an edge at which the bit enable is high.
- R10: In the idle state, a bit enable that sees the sync request high starts a repetition and puts that repetition's bit 0 on the line in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pat_wr_en | input | 1 | Pattern register write enable |
| pat_wr_data | input | 16 | Value to write into the pattern register |
| pat_rd_data | output | 16 | Current contents of the pattern register |
| bit_en | input | 1 | Serial bit enable, one pulse per line bit |
| sync_req | input | 1 | High while sync words are wanted |
| tx_data | output | 1 | Serial line output, registered |
| tx_active | output | 1 | High while a repetition is on the line |
| pat_done | output | 1 | One-clock strobe with the last bit of each repetition |

## Verification
Every line result is due in the clock cycle after the bit-enable edge that causes it, and a register readback is due in the cycle after the write edge. The bench drives each stimulus for one clock from the falling edge and compares the outputs at the next falling edge against a behavioural model of the stream. It then holds the bit enable low for one more clock and checks that the line is unchanged and the strobe has dropped. Writes and bit enables never fall in the same cycle, so the model's snapshot point is always unambiguous.

// File: rtl/sync_tx_pkg.sv
package sync_tx_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_SEND = 1'b1} tx_state_e;
endpackage

// File: rtl/sync_pat_reg.sv
module sync_pat_reg #(
  parameter int             PAT_W     = 16,
  parameter logic [PAT_W-1:0] RESET_PAT = 16'h7E7E
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [PAT_W-1:0] wr_data,
  output logic [PAT_W-1:0] pat_q
);
  always_ff @(posedge clk) begin
    if (rst) pat_q <= RESET_PAT;
    else if (wr_en) pat_q <= wr_data;
  end

  // R1: a write lands in the register by the next cycle
  assert_write_lands_R1: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (pat_q == $past(wr_data)));
  // R1: without a write the register keeps its value
  assert_write_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(pat_q));
endmodule

// File: rtl/sync_bit_ctr.sv
module sync_bit_ctr #(
  parameter int PAT_W = 16,
  localparam int CNT_W = $clog2(PAT_W + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic adv,
  input  logic clr,
  output logic at_end,
  output logic before_end
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PAT_W);
  localparam logic [CNT_W-1:0] PREV = CNT_W'(PAT_W - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (load) cnt_q <= CNT_W'(1);
    else if (adv) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign at_end     = (cnt_q == LAST);
  assign before_end = (cnt_q == PREV);

  // R4: the count of emitted bits never passes the word length
  assert_cnt_range_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
endmodule

// File: rtl/sync_pat_shifter.sv
module sync_pat_shifter
  import sync_tx_pkg::*;
#(
  parameter int   PAT_W      = 16,
  parameter logic IDLE_LEVEL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             sync_req,
  input  logic [PAT_W-1:0] pat_cur,
  input  logic             at_end,
  input  logic             before_end,
  output logic             ctr_load,
  output logic             ctr_adv,
  output logic             ctr_clr,
  output logic             tx_data,
  output logic             active,
  output logic             done
);
  tx_state_e        st_q;
  logic [PAT_W-1:0] sh_q;
  logic             start, stop, step;

  always_comb begin
    start = bit_en && sync_req && ((st_q == ST_IDLE) || at_end);
    stop  = bit_en && !sync_req && (st_q == ST_SEND) && at_end;
    step  = bit_en && (st_q == ST_SEND) && !at_end;
  end

  assign ctr_load = start;
  assign ctr_adv  = step;
  assign ctr_clr  = stop;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      sh_q    <= '0;
      tx_data <= IDLE_LEVEL;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        st_q    <= ST_SEND;
        tx_data <= pat_cur[0];
        sh_q    <= pat_cur >> 1;
      end else if (stop) begin
        st_q    <= ST_IDLE;
        tx_data <= IDLE_LEVEL;
      end else if (step) begin
        tx_data <= sh_q[0];
        sh_q    <= sh_q >> 1;
        done    <= before_end;
      end
    end
  end

  assign active = (st_q == ST_SEND);

  // R9: line and state only move on a bit enable
  assert_hold_line_R9: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> ($stable(tx_data) && $stable(st_q)));
  // R8: idle means idle level
  assert_idle_level_R8: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE) |-> (tx_data == IDLE_LEVEL));
  // R5: strobe only during a repetition and never two cycles running
  assert_done_active_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> (st_q == ST_SEND));
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R6: the private copy is frozen between bit enables
  assert_snapshot_R6: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_SEND) && !bit_en) |=> $stable(sh_q));
  // R7: no release before the final bit
  assert_no_early_stop_R7: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_SEND) && !at_end) |=> (st_q == ST_SEND));
endmodule

// File: rtl/sync_pattern_tx.sv
module sync_pattern_tx #(
  parameter int               PAT_W      = 16,
  parameter logic [PAT_W-1:0] RESET_PAT  = 16'h7E7E,
  parameter logic             IDLE_LEVEL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pat_wr_en,
  input  logic [PAT_W-1:0] pat_wr_data,
  output logic [PAT_W-1:0] pat_rd_data,
  input  logic             bit_en,
  input  logic             sync_req,
  output logic             tx_data,
  output logic             tx_active,
  output logic             pat_done
);
  logic [PAT_W-1:0] pat_q;
  logic             at_end, before_end;
  logic             ctr_load, ctr_adv, ctr_clr;

  sync_pat_reg #(.PAT_W(PAT_W), .RESET_PAT(RESET_PAT)) u_reg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (pat_wr_en),
    .wr_data (pat_wr_data),
    .pat_q   (pat_q)
  );

  sync_bit_ctr #(.PAT_W(PAT_W)) u_ctr (
    .clk        (clk),
    .rst        (rst),
    .load       (ctr_load),
    .adv        (ctr_adv),
    .clr        (ctr_clr),
    .at_end     (at_end),
    .before_end (before_end)
  );

  sync_pat_shifter #(.PAT_W(PAT_W), .IDLE_LEVEL(IDLE_LEVEL)) u_shf (
    .clk        (clk),
    .rst        (rst),
    .bit_en     (bit_en),
    .sync_req   (sync_req),
    .pat_cur    (pat_q),
    .at_end     (at_end),
    .before_end (before_end),
    .ctr_load   (ctr_load),
    .ctr_adv    (ctr_adv),
    .ctr_clr    (ctr_clr),
    .tx_data    (tx_data),
    .active     (tx_active),
    .done       (pat_done)
  );

  assign pat_rd_data = pat_q;

  // R10: a request seen on a bit enable while idle starts a word
  assert_start_R10: assert property (@(posedge clk) disable iff (rst)
    (!tx_active && bit_en && sync_req) |=> tx_active);
endmodule

// File: tb/sync_pattern_tx_tb.sv
module sync_pattern_tx_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pat_wr_en = 1'b0;
  logic [15:0] pat_wr_data = '0;
  logic [15:0] pat_rd_data;
  logic        bit_en = 1'b0;
  logic        sync_req = 1'b0;
  logic        tx_data, tx_active, pat_done;

  int checks = 0;
  int fails  = 0;

  logic [15:0] m_reg  = 16'h7E7E;
  logic [15:0] m_snap = '0;
  int          m_idx  = 0;
  bit          m_act  = 0;

  always #5 clk = ~clk;

  sync_pattern_tx u_dut (
    .clk(clk), .rst(rst), .pat_wr_en(pat_wr_en), .pat_wr_data(pat_wr_data),
    .pat_rd_data(pat_rd_data), .bit_en(bit_en), .sync_req(sync_req),
    .tx_data(tx_data), .tx_active(tx_active), .pat_done(pat_done)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one bit enable, then one quiet cycle; model follows R3/R4/R7/R10
  task automatic tick(input string req);
    logic prev_tx;
    bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
    if (!m_act) begin
      if (sync_req) begin m_act = 1; m_snap = m_reg; m_idx = 0; end
    end else if (m_idx == 15) begin
      if (sync_req) begin m_snap = m_reg; m_idx = 0; end
      else m_act = 0;
    end else m_idx++;
    chk(req, "tx_data", tx_data, m_act ? m_snap[m_idx] : 1);
    chk(req, "tx_active", tx_active, m_act);
    chk("R5", "pat_done", pat_done, (m_act && m_idx == 15) ? 1 : 0);
    prev_tx = tx_data;
    @(negedge clk);
    chk("R9", "tx hold", tx_data, prev_tx);
    chk("R5", "pat_done drop", pat_done, 0);
  endtask

  task automatic wr(input logic [15:0] v);
    pat_wr_en = 1'b1;
    pat_wr_data = v;
    @(negedge clk);
    pat_wr_en = 1'b0;
    m_reg = v;
    chk("R1", "readback", pat_rd_data, v);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R2: reset state
    chk("R2", "rd", pat_rd_data, 16'h7E7E);
    chk("R2", "tx", tx_data, 1);
    chk("R2", "active", tx_active, 0);
    chk("R2", "done", pat_done, 0);

    // R8: bit enables and a write while idle leave the line high
    for (int i = 0; i < 4; i++) tick("R8");
    wr(16'h7E7E);

    // R10/R3/R4: default flags, two back-to-back words
    sync_req = 1'b1;
    tick("R10");
    for (int i = 0; i < 31; i++) tick("R4");

    // R6: write mid-word; remainder old, next word new
    for (int i = 0; i < 5; i++) tick("R3");
    wr(16'hD555);
    for (int i = 0; i < 11; i++) tick("R6");
    for (int i = 0; i < 16; i++) tick("R6");

    // R7: drop the request mid-word; the word finishes then releases
    for (int i = 0; i < 3; i++) tick("R3");
    sync_req = 1'b0;
    for (int i = 0; i < 13; i++) tick("R7");
    tick("R7");
    tick("R8");
    chk("R7", "released", tx_active, 0);

    // R3: sweep single-bit and single-hole patterns
    for (int k = 0; k < 16; k++) begin
      wr(16'(1) << k);
      sync_req = 1'b1;
      tick("R10");
      sync_req = 1'b0;
      for (int i = 0; i < 16; i++) tick("R3");
      wr(~(16'(1) << k));
      sync_req = 1'b1;
      for (int i = 0; i < 17; i++) tick("R3");
      sync_req = 1'b0;
      for (int i = 0; i < 16; i++) tick("R7");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule